// File: doc/BRIEF.md
# Asynchronous Parallel Memory Bus Front-End

This block is the device-side control front end of an asynchronous parallel memory. The host drives two active-low chip enables, an output enable, a write enable, an active-low reset/power-down, a byte-mode select, an address bus and a 16-bit data bus. The block oversamples all of them on a fast internal clock. It works out when the device is selected and resolves priority among the strobes. It captures addresses and words on the write-strobe edges and passes them to a downstream command interpreter. It steers bytes when the bus is 8 bits wide, and it decides when and on which byte lanes the device may drive the data bus.

The storage array, the command interpreter and the internal operation sequencer are not part of this block. They appear as hand-off ports: a one-cycle command pulse with its decoded address fields, a page-buffer address, a read-mode setting input, four read-data sources, and abort and status-clear outputs that are active while the reset pin is low.

Top module: `pmem_front`

## Requirements
- R1: The device counts as selected only while both `pin_ce0_n` and `pin_ce1_n` are low and `pin_rp_n` is high. With only one enable low, `pin_dq_oe_lo` and `pin_dq_oe_hi` stay 0 even when `pin_oe_n` is low.
- R2: A rise on either chip enable ends selection. After that the drive enables return to 0, and write-strobe edges produce no `cmd_valid` and leave `pb_addr` unchanged.
- R3: Output enable takes priority over write enable. While selected with `pin_oe_n` low, write-strobe edges produce no `cmd_valid` and leave `pb_addr` unchanged.
- R4: While selected with `pin_oe_n` low, in x16 mode (`pin_byte_n` high) and in a non-status read mode, both lane enables are 1 and `pin_dq_out` carries the full word of the selected source.
- R5: Each accepted rise of `pin_we_n` (selected, `pin_oe_n` high) gives exactly one `cmd_valid` pulse of one clock cycle, carrying the address and data present at that rise.
- R6: Each accepted fall of `pin_we_n` loads the full address present at that fall into `pb_addr`. A later address change before the rise does not alter it.
- R7: At a command pulse, `cmd_blk` is address bits [20:16], `cmd_row` is bits [15:6] and `cmd_col` is bits [5:1].
- R8: In x16 mode a command carries all 16 data bits and `cmd_bsel` is 0. In x8 mode (`pin_byte_n` low) `cmd_data` is {8'h00, data[7:0]} and `cmd_bsel` is address bit 0.
- R9: An x8 read drives only the low lane (`pin_dq_oe_hi` = 0). `pin_dq_out` is {8'h00, high byte of the source} when address bit 0 is 1, and {8'h00, low byte} when it is 0.
- R10: In status read mode only the low lane is driven, and `pin_dq_out` is {8'h00, `rd_status`}.
- R11: On a `mode_set` cycle the read mode becomes `mode_val` (0 array, 1 buffer, 2 identifier, 3 status), and that source appears on the bus.
- R12: While `pin_rp_n` is low, `op_abort` and `status_clear` are 1, neither lane is driven and no command pulse is produced.
- R13: After `pin_rp_n` returns high, the read mode is array, whatever mode was set before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal sampling clock |
| rst_n | input | 1 | Synchronous active-low block reset |
| pin_ce0_n | input | 1 | Chip enable 0, active low |
| pin_ce1_n | input | 1 | Chip enable 1, active low |
| pin_oe_n | input | 1 | Output enable, active low |
| pin_we_n | input | 1 | Write strobe, active low |
| pin_rp_n | input | 1 | Reset/power-down, active low |
| pin_byte_n | input | 1 | Low selects x8 mode, high selects x16 |
| pin_addr | input | 21 | Address bus |
| pin_dq_in | input | 16 | Data bus, input side |
| pin_dq_out | output | 16 | Data bus, output side |
| pin_dq_oe_lo | output | 1 | Drive enable, low byte lane |
| pin_dq_oe_hi | output | 1 | Drive enable, high byte lane |
| mode_set | input | 1 | Load read mode from interpreter |
| mode_val | input | 2 | Read mode code |
| rd_array | input | 16 | Array read data |
| rd_buf | input | 16 | Buffer read data |
| rd_ident | input | 16 | Identifier read data |
| rd_status | input | 8 | Status read data |
| cmd_valid | output | 1 | One-cycle command/data pulse |
| cmd_data | output | 16 | Captured data or command word |
| cmd_blk | output | 5 | Captured erase-block field |
| cmd_row | output | 10 | Captured row field |
| cmd_col | output | 5 | Captured column-group field |
| cmd_bsel | output | 1 | Captured byte select (x8) |
| pb_addr | output | 21 | Address captured on write-strobe fall |
| op_abort | output | 1 | Abort internal operation (reset pin low) |
| status_clear | output | 1 | Return status to ready (reset pin low) |

## Verification
The hardest case is the page-buffer address that is latched at the falling strobe edge and kept apart from the command address latched at the rising edge. The stimulus therefore changes the address bus while the write strobe is low, and checks that `pb_addr` still holds the fall-time value while the command carries the rise-time value. A second hard case is a strobe that must be ignored: the write is pulsed with output enable low, and again with one chip enable high. The scoreboard then has to see no pulse at all, and `pb_addr` has to keep its earlier value. Read mode recovery is reached by setting status mode and then pulsing the reset pin.

// File: rtl/pmem_pkg.sv
// Shared types for the parallel memory front end.
package pmem_pkg;
    // Read source selection; code values are fixed by the mode input encoding.
    typedef enum logic [1:0] {
        RM_ARRAY  = 2'd0,
        RM_BUFFER = 2'd1,
        RM_IDENT  = 2'd2,
        RM_STATUS = 2'd3
    } rd_mode_e;
endpackage

// File: rtl/pmem_sync.sv
// Two-flop synchronizer with a third stage that keeps the previous sample
// for edge detection. Assumes each bit is sampled independently; multi-bit
// buses passed through here must be held stable around the strobe edges.
module pmem_sync #(
    parameter int           W   = 1,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] q_prev
);
    logic [W-1:0] s1, s2, s3;

    // Shift the asynchronous input through meta, stable and history stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= RST;
            s2 <= RST;
            s3 <= RST;
        end else begin
            s1 <= d;
            s2 <= s1;
            s3 <= s2;
        end
    end

    assign q      = s2;
    assign q_prev = s3;
endmodule

// File: rtl/pmem_ctrl.sv
// Control-pin resolution: selection from both enables and reset pin,
// priority enable > output enable > write enable, and strobe edge events.
// Assumes synchronized inputs.
module pmem_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic ce0_s,
    input  logic ce1_s,
    input  logic oe_s,
    input  logic we_s,
    input  logic we_p,
    input  logic rp_s,
    output logic sel,
    output logic rd_drive,
    output logic we_fall,
    output logic we_rise,
    output logic in_reset
);
    logic wr_allow;

    // Resolve selection and strobe priority from the synchronized pins.
    always_comb begin
        in_reset = !rp_s;
        sel      = !ce0_s && !ce1_s && rp_s;
        rd_drive = sel && !oe_s;
        wr_allow = sel && oe_s;
        we_fall  = wr_allow && !we_s && we_p;
        we_rise  = wr_allow && we_s && !we_p;
    end

    // R5: a rise and a fall of the strobe never coincide
    a_r5_single_edge: assert property (@(posedge clk) disable iff (!rst_n)
        !(we_rise && we_fall));
endmodule

// File: rtl/pmem_latch.sv
// Strobe-edge capture: page-buffer address on the accepted fall, address
// fields and data on the accepted rise with a one-cycle valid pulse.
// Assumes address bits are [blk | row | col | byte].
module pmem_latch #(
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 5
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           in_reset,
    input  logic                           we_fall,
    input  logic                           we_rise,
    input  logic                           x8,
    input  logic [BLK_W+ROW_W+COL_W:0]     addr,
    input  logic [DATA_W-1:0]              dq,
    output logic                           cmd_valid,
    output logic [DATA_W-1:0]              cmd_data,
    output logic [BLK_W-1:0]               cmd_blk,
    output logic [ROW_W-1:0]               cmd_row,
    output logic [COL_W-1:0]               cmd_col,
    output logic                           cmd_bsel,
    output logic [BLK_W+ROW_W+COL_W:0]     pb_addr
);
    localparam int BYTE_W  = DATA_W / 2;
    localparam int COL_LSB = 1;
    localparam int ROW_LSB = COL_LSB + COL_W;
    localparam int BLK_LSB = ROW_LSB + ROW_W;

    // Load the page-buffer address on each accepted falling strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       pb_addr <= '0;
        else if (we_fall) pb_addr <= addr;
    end

    // Capture command fields and raise the valid pulse on an accepted rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_valid <= 1'b0;
            cmd_data  <= '0;
            cmd_blk   <= '0;
            cmd_row   <= '0;
            cmd_col   <= '0;
            cmd_bsel  <= 1'b0;
        end else begin
            cmd_valid <= we_rise && !in_reset;
            if (we_rise) begin
                cmd_blk  <= addr[BLK_LSB +: BLK_W];
                cmd_row  <= addr[ROW_LSB +: ROW_W];
                cmd_col  <= addr[COL_LSB +: COL_W];
                cmd_bsel <= x8 && addr[0];
                cmd_data <= x8 ? {{BYTE_W{1'b0}}, dq[BYTE_W-1:0]} : dq;
            end
        end
    end

    // R5: the command pulse lasts one cycle
    a_r5_pulse_one: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);
    // R6: page-buffer address moves only after an accepted fall
    a_r6_pb_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(pb_addr) |-> $past(we_fall));
endmodule

// File: rtl/pmem_rdmux.sv
// Read path: read-mode register, source select, x8 byte steering and the
// per-lane drive enables. Assumes status data is one byte wide.
module pmem_rdmux #(
    parameter int DATA_W = 16
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_reset,
    input  logic                  mode_set,
    input  logic [1:0]            mode_val,
    input  logic                  rd_drive,
    input  logic                  x8,
    input  logic                  bsel_live,
    input  logic [DATA_W-1:0]     rd_array,
    input  logic [DATA_W-1:0]     rd_buf,
    input  logic [DATA_W-1:0]     rd_ident,
    input  logic [DATA_W/2-1:0]   rd_status,
    output logic [DATA_W-1:0]     dq_out,
    output logic                  oe_lo,
    output logic                  oe_hi
);
    import pmem_pkg::*;
    localparam int BYTE_W = DATA_W / 2;

    rd_mode_e          mode_q;
    logic [DATA_W-1:0] word;

    // Hold the read mode; reset and reset-pin low both force array mode.
    always_ff @(posedge clk) begin
        if (!rst_n || in_reset) mode_q <= RM_ARRAY;
        else if (mode_set)      mode_q <= rd_mode_e'(mode_val);
    end

    // Pick the source word and steer bytes onto the lanes.
    always_comb begin
        case (mode_q)
            RM_BUFFER: word = rd_buf;
            RM_IDENT:  word = rd_ident;
            RM_STATUS: word = {{BYTE_W{1'b0}}, rd_status};
            default:   word = rd_array;
        endcase
        if (mode_q == RM_STATUS || !x8) dq_out = word;
        else if (bsel_live)             dq_out = {{BYTE_W{1'b0}}, word[DATA_W-1:BYTE_W]};
        else                            dq_out = {{BYTE_W{1'b0}}, word[BYTE_W-1:0]};
        oe_lo = rd_drive;
        oe_hi = rd_drive && !x8 && (mode_q != RM_STATUS);
    end

    // R10: status mode never drives the high lane
    a_r10_status_low_only: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == RM_STATUS) |-> !oe_hi);
    // R13: leaving reset finds array mode
    a_r13_array_on_exit: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_reset) |-> (mode_q == RM_ARRAY));
endmodule

// File: rtl/pmem_front.sv
// Top of the parallel memory front end: synchronizes all pins, resolves
// control, captures commands and drives the read path. Assumes the host
// holds address and data stable for a few clocks around each strobe edge.
module pmem_front #(
    parameter int DATA_W = 16,
    parameter int BLK_W  = 5,
    parameter int ROW_W  = 10,
    parameter int COL_W  = 5
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              pin_ce0_n,
    input  logic                              pin_ce1_n,
    input  logic                              pin_oe_n,
    input  logic                              pin_we_n,
    input  logic                              pin_rp_n,
    input  logic                              pin_byte_n,
    input  logic [BLK_W+ROW_W+COL_W:0]        pin_addr,
    input  logic [DATA_W-1:0]                 pin_dq_in,
    output logic [DATA_W-1:0]                 pin_dq_out,
    output logic                              pin_dq_oe_lo,
    output logic                              pin_dq_oe_hi,
    input  logic                              mode_set,
    input  logic [1:0]                        mode_val,
    input  logic [DATA_W-1:0]                 rd_array,
    input  logic [DATA_W-1:0]                 rd_buf,
    input  logic [DATA_W-1:0]                 rd_ident,
    input  logic [DATA_W/2-1:0]               rd_status,
    output logic                              cmd_valid,
    output logic [DATA_W-1:0]                 cmd_data,
    output logic [BLK_W-1:0]                  cmd_blk,
    output logic [ROW_W-1:0]                  cmd_row,
    output logic [COL_W-1:0]                  cmd_col,
    output logic                              cmd_bsel,
    output logic [BLK_W+ROW_W+COL_W:0]        pb_addr,
    output logic                              op_abort,
    output logic                              status_clear
);
    localparam int ADDR_W = 1 + COL_W + ROW_W + BLK_W;
    localparam int BUS_W  = ADDR_W + DATA_W;
    localparam int CTL_W  = 6;

    logic [CTL_W-1:0]  ctl_s, ctl_p;
    logic [BUS_W-1:0]  bus_s, bus_p;
    logic              ce0_s, ce1_s, oe_s, we_s, we_p, rp_s, byte_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] dq_s;
    logic              sel, rd_drive, we_fall, we_rise, in_reset;

    pmem_sync #(.W(CTL_W), .RST({CTL_W{1'b1}})) u_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({pin_ce0_n, pin_ce1_n, pin_oe_n, pin_we_n, pin_rp_n, pin_byte_n}),
        .q(ctl_s), .q_prev(ctl_p));

    pmem_sync #(.W(BUS_W), .RST('0)) u_bus_sync (
        .clk(clk), .rst_n(rst_n), .d({pin_addr, pin_dq_in}),
        .q(bus_s), .q_prev(bus_p));

    assign {ce0_s, ce1_s, oe_s, we_s, rp_s, byte_s} = ctl_s;
    assign we_p   = ctl_p[2];
    assign addr_s = bus_s[BUS_W-1:DATA_W];
    assign dq_s   = bus_s[DATA_W-1:0];

    pmem_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .ce0_s(ce0_s), .ce1_s(ce1_s), .oe_s(oe_s),
        .we_s(we_s), .we_p(we_p), .rp_s(rp_s), .sel(sel), .rd_drive(rd_drive),
        .we_fall(we_fall), .we_rise(we_rise), .in_reset(in_reset));

    pmem_latch #(.DATA_W(DATA_W), .BLK_W(BLK_W), .ROW_W(ROW_W), .COL_W(COL_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .we_fall(we_fall),
        .we_rise(we_rise), .x8(!byte_s), .addr(addr_s), .dq(dq_s),
        .cmd_valid(cmd_valid), .cmd_data(cmd_data), .cmd_blk(cmd_blk),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_bsel(cmd_bsel),
        .pb_addr(pb_addr));

    pmem_rdmux #(.DATA_W(DATA_W)) u_rdmux (
        .clk(clk), .rst_n(rst_n), .in_reset(in_reset), .mode_set(mode_set),
        .mode_val(mode_val), .rd_drive(rd_drive), .x8(!byte_s),
        .bsel_live(addr_s[0]), .rd_array(rd_array), .rd_buf(rd_buf),
        .rd_ident(rd_ident), .rd_status(rd_status), .dq_out(pin_dq_out),
        .oe_lo(pin_dq_oe_lo), .oe_hi(pin_dq_oe_hi));

    // Abort and status-clear follow the synchronized reset pin.
    assign op_abort     = in_reset;
    assign status_clear = in_reset;

    // R2: with an enable high, no command follows
    a_r2_desel_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        (ce0_s || ce1_s) |=> !cmd_valid);
    // R3: output enable low blocks commands
    a_r3_oe_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !oe_s) |=> !cmd_valid);
    // R12: reset pin low means no drive and no command
    a_r12_reset_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_s |-> (!pin_dq_oe_lo && !pin_dq_oe_hi));
    a_r12_reset_no_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !rp_s |=> !cmd_valid);
endmodule

// File: tb/pmem_front_tb_top.sv
module pmem_front_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pin_ce0_n = 1'b1, pin_ce1_n = 1'b1, pin_oe_n = 1'b1;
    logic        pin_we_n = 1'b1, pin_rp_n = 1'b1, pin_byte_n = 1'b1;
    logic [20:0] pin_addr = '0;
    logic [15:0] pin_dq_in = '0;
    logic [15:0] pin_dq_out;
    logic        pin_dq_oe_lo, pin_dq_oe_hi;
    logic        mode_set = 1'b0;
    logic [1:0]  mode_val = 2'd0;
    logic [15:0] rd_array = 16'hA1B2, rd_buf = 16'hC3D4, rd_ident = 16'h5E6F;
    logic [7:0]  rd_status = 8'h80;
    logic        cmd_valid, cmd_bsel, op_abort, status_clear;
    logic [15:0] cmd_data;
    logic [4:0]  cmd_blk, cmd_col;
    logic [9:0]  cmd_row;
    logic [20:0] pb_addr;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;
    logic [36:0] exp_q[$];

    always #10 clk = ~clk;

    pmem_front dut_i (
        .clk(clk), .rst_n(rst_n), .pin_ce0_n(pin_ce0_n), .pin_ce1_n(pin_ce1_n),
        .pin_oe_n(pin_oe_n), .pin_we_n(pin_we_n), .pin_rp_n(pin_rp_n),
        .pin_byte_n(pin_byte_n), .pin_addr(pin_addr), .pin_dq_in(pin_dq_in),
        .pin_dq_out(pin_dq_out), .pin_dq_oe_lo(pin_dq_oe_lo),
        .pin_dq_oe_hi(pin_dq_oe_hi), .mode_set(mode_set), .mode_val(mode_val),
        .rd_array(rd_array), .rd_buf(rd_buf), .rd_ident(rd_ident),
        .rd_status(rd_status), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
        .cmd_blk(cmd_blk), .cmd_row(cmd_row), .cmd_col(cmd_col),
        .cmd_bsel(cmd_bsel), .pb_addr(pb_addr), .op_abort(op_abort),
        .status_clear(status_clear));

    task automatic chk(input string tag, input logic [36:0] got, input logic [36:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Monitor: pop the expected command on every pulse and compare.
    always @(negedge clk) begin
        if (rst_n && cmd_valid) begin
            if (exp_q.size() == 0) begin
                chk("R2 R3 R5 unexpected pulse", 37'd1, 37'd0);
            end else begin
                chk("R5 R7 R8 command", {cmd_bsel, cmd_blk, cmd_row, cmd_col, cmd_data},
                    exp_q.pop_front());
            end
        end
    end

    // Driver: one write cycle; address changes while the strobe is low.
    task automatic do_write(input logic [20:0] a_fall, input logic [20:0] a_rise,
                            input logic [15:0] d, input bit accept);
        logic [20:0] pb_before;
        pb_before = pb_addr;
        pin_addr = a_fall; pin_dq_in = d;
        idle(3);
        pin_we_n = 1'b0;
        idle(4);
        if (accept) chk("R6 pb at fall", {16'd0, pb_addr}, {16'd0, a_fall});
        else        chk("R2 R3 pb unchanged", {16'd0, pb_addr}, {16'd0, pb_before});
        pin_addr = a_rise;
        idle(3);
        if (accept) begin
            if (pin_byte_n)
                exp_q.push_back({1'b0, a_rise[20:16], a_rise[15:6], a_rise[5:1], d});
            else
                exp_q.push_back({a_rise[0], a_rise[20:16], a_rise[15:6], a_rise[5:1],
                                 8'h00, d[7:0]});
        end
        pin_we_n = 1'b1;
        idle(5);
    endtask

    task automatic set_mode(input logic [1:0] m);
        mode_val = m; mode_set = 1'b1;
        idle(1);
        mode_set = 1'b0;
        idle(1);
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(3);
        chk("reset state R12", {34'd0, pin_dq_oe_lo, cmd_valid, op_abort}, 37'd0);

        // R1: one enable low is not selection
        pin_ce0_n = 1'b0; pin_oe_n = 1'b0;
        idle(4);
        chk("R1 one enable", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd0);
        pin_ce1_n = 1'b0;
        idle(4);
        chk("R1 R4 both enables", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd3);
        chk("R4 array word", {21'd0, pin_dq_out}, {21'd0, rd_array});

        // R2: first rising enable deselects
        pin_ce0_n = 1'b1;
        idle(4);
        chk("R2 deselect", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd0);
        pin_ce0_n = 1'b0;
        idle(4);

        // R11: each mode routes its source
        set_mode(2'd1); idle(2);
        chk("R11 buffer", {21'd0, pin_dq_out}, {21'd0, rd_buf});
        set_mode(2'd2); idle(2);
        chk("R11 ident", {21'd0, pin_dq_out}, {21'd0, rd_ident});
        set_mode(2'd3); idle(2);
        chk("R10 status data", {21'd0, pin_dq_out}, {29'd0, rd_status});
        chk("R10 status lanes", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd2);
        set_mode(2'd0); idle(2);
        chk("R11 array", {21'd0, pin_dq_out}, {21'd0, rd_array});

        // R5 R6 R7 R8: x16 writes
        pin_oe_n = 1'b1;
        idle(4);
        do_write(21'h0ABCDE, 21'h1F3C5B, 16'hBEEF, 1'b1);
        do_write(21'h000041, 21'h10FFC3, 16'h1357, 1'b1);

        // R3: strobe ignored while outputs enabled
        pin_oe_n = 1'b0;
        idle(4);
        do_write(21'h155555, 21'h0AAAAA, 16'h2222, 1'b0);
        pin_oe_n = 1'b1;
        idle(4);

        // R2: strobe ignored while deselected
        pin_ce1_n = 1'b1;
        idle(4);
        do_write(21'h033333, 21'h044444, 16'h3333, 1'b0);
        pin_ce1_n = 1'b0;
        idle(4);

        // R8: x8 program latches byte select and low byte
        pin_byte_n = 1'b0;
        idle(4);
        do_write(21'h012345, 21'h054321, 16'hA55A, 1'b1);

        // R9: x8 reads steer by address bit 0
        pin_oe_n = 1'b0; pin_addr = 21'h000001;
        idle(4);
        chk("R9 x8 high byte", {21'd0, pin_dq_out}, {29'd0, rd_array[15:8]});
        chk("R9 x8 lanes", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd2);
        pin_addr = 21'h000000;
        idle(4);
        chk("R9 x8 low byte", {21'd0, pin_dq_out}, {29'd0, rd_array[7:0]});
        pin_byte_n = 1'b1;

        // R12 R13: reset pin forces quiet state, then array mode
        set_mode(2'd3);
        pin_rp_n = 1'b0;
        idle(4);
        chk("R12 abort clear", {35'd0, op_abort, status_clear}, 37'd3);
        chk("R12 no drive", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd0);
        pin_rp_n = 1'b1;
        idle(4);
        chk("R12 abort released", {35'd0, op_abort, status_clear}, 37'd0);
        chk("R13 array after reset", {21'd0, pin_dq_out}, {21'd0, rd_array});
        chk("R13 lanes", {35'd0, pin_dq_oe_lo, pin_dq_oe_hi}, 37'd3);

        idle(5);
        chk("R5 all commands seen", 37'(exp_q.size()), 37'd0);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog got=timeout exp=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule